// File: doc/BRIEF.md
# Serial Port Interrupt Vector Unit

This block is the interrupt bookkeeping of a UART-style serial controller. Seven event sources report into a flag register: wake-up, parity error, framing error, break, overrun, receive ready and transmit ready. In this block each source is a one-cycle strobe. A set/clear pair of enable registers decides which flags may raise an interrupt. A second set/clear pair of level registers sends each source to interrupt level 0 or level 1. Out of reset, every source goes to level 1.

Each level has its own interrupt request output. Each level also has a vector output that gives a fixed code for the highest-priority pending source among those that are enabled and routed to that level. Software reads a vector by pulsing that level's read strobe. The read clears the flag of the source that was reported and leaves the other flags alone. Software can also clear any flag directly by writing a one to its bit.

Top module: `sio_irq_vector`

## Requirements
- R1: After reset all flags and enables are clear, every source is routed to level 1 (`level_o` all zero), both vectors read 0 and both interrupt outputs are low.
- R2: Event strobe `evt_i` index i maps to one flag bit: 0 wake-up (bit 1), 1 parity (bit 24), 2 framing (bit 26), 3 break (bit 0), 4 overrun (bit 25), 5 receive (bit 9), 6 transmit (bit 8). A strobe sets its flag on the next clock edge. The enable and level registers use the same bit positions, and all other bits read 0.
- R3: Each vector output gives code 1 for wake-up, 3 for parity, 6 for framing, 7 for break, 9 for overrun, 11 for receive and 12 for transmit, and 0 when nothing is pending on that level.
- R4: When several sources are pending on a level, the lowest code wins. For example, overrun together with receive gives 9.
- R5: A pulse on a level's read strobe clears the flag of the source that its vector is showing in that cycle. All other flags stay as they were.
- R6: A write with select 0 clears exactly those flags whose data bits are one. Writing only bit 25 clears only the overrun flag, and ones on unused bits have no effect.
- R7: Select 1 sets enable bits and select 2 clears them, both for the bits written as one. A flag that is set but not enabled never shows in a vector and never drives an interrupt output.
- R8: Select 3 moves the sources written as one to level 0 and select 4 moves them back to level 1. The level register reads 1 for sources on level 0.
- R9: `irq0_o` (level 0) and `irq1_o` (level 1) are each high exactly when a flag that is enabled and routed to that level is set, which is also exactly when that level's vector is nonzero.
- R10: An event strobe in the same cycle as a read-clear of the same flag leaves the flag set.
- R11: Writes with a select of 5, 6 or 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 7 | One-cycle event strobes, indexed as in R2 |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select: 0 flag clear, 1 enable set, 2 enable clear, 3 level-0 set, 4 level-0 clear |
| wr_data_i | input | 32 | Write data, one bit per source position |
| vec0_rd_i | input | 1 | Read strobe for the level 0 vector (clears the reported flag) |
| vec1_rd_i | input | 1 | Read strobe for the level 1 vector (clears the reported flag) |
| flag_o | output | 32 | Flag register contents |
| enable_o | output | 32 | Enable register contents |
| level_o | output | 32 | Level register contents (1 = level 0) |
| vec0_o | output | 4 | Level 0 vector code |
| vec1_o | output | 4 | Level 1 vector code |
| irq0_o | output | 1 | Level 0 interrupt request |
| irq1_o | output | 1 | Level 1 interrupt request |

## Verification
The flag, enable and level registers change on the first clock edge after a strobe, a write or a vector read. The vectors and interrupt outputs are combinational from those registers, so they follow in the same cycle as the new state. The bench changes inputs on a falling edge and samples on the next falling edge, one rising edge later. Before the clearing edge it samples the vector during the read strobe, and after that edge it samples the flags. A sweep over every combination of pending sources under several level splits drains each level one read at a time. At each read it compares the code against a minimum-code model.

// File: rtl/sirq_pkg.sv
`timescale 1ns/1ps
package sirq_pkg;
  localparam int NSRC   = 7;
  localparam int DATA_W = 32;
  localparam int CODE_W = 4;

  localparam logic [2:0] SEL_FLAG_CLR = 3'd0;
  localparam logic [2:0] SEL_EN_SET   = 3'd1;
  localparam logic [2:0] SEL_EN_CLR   = 3'd2;
  localparam logic [2:0] SEL_LVL_SET  = 3'd3;
  localparam logic [2:0] SEL_LVL_CLR  = 3'd4;

  // register bit position of source index i (index order = priority order)
  function automatic int unsigned src_bit(input int i);
    case (i)
      0: return 1;
      1: return 24;
      2: return 26;
      3: return 0;
      4: return 25;
      5: return 9;
      default: return 8;
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] src_code(input int i);
    case (i)
      0: return 4'd1;
      1: return 4'd3;
      2: return 4'd6;
      3: return 4'd7;
      4: return 4'd9;
      5: return 4'd11;
      default: return 4'd12;
    endcase
  endfunction

  function automatic logic [NSRC-1:0] gather(input logic [DATA_W-1:0] w);
    logic [NSRC-1:0] g;
    for (int i = 0; i < NSRC; i++) g[i] = w[src_bit(i)];
    return g;
  endfunction

  function automatic logic [DATA_W-1:0] scatter(input logic [NSRC-1:0] s);
    logic [DATA_W-1:0] w;
    w = '0;
    for (int i = 0; i < NSRC; i++) w[src_bit(i)] = s[i];
    return w;
  endfunction
endpackage

// File: rtl/sirq_regs.sv
`timescale 1ns/1ps
module sirq_regs
  import sirq_pkg::*;
#(
  parameter int N = NSRC,
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         wr_en,
  input  logic [2:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic [N-1:0] rd_clr,
  output logic [N-1:0] flag_q,
  output logic [N-1:0] en_q,
  output logic [N-1:0] lvl0_q
);
  logic [N-1:0] wsrc;
  logic [N-1:0] w1c_clr;
  logic [N-1:0] en_set, en_clr, lv_set, lv_clr;

  assign wsrc    = gather(wr_data);
  assign w1c_clr = (wr_en && wr_sel == SEL_FLAG_CLR) ? wsrc : '0;
  assign en_set  = (wr_en && wr_sel == SEL_EN_SET)   ? wsrc : '0;
  assign en_clr  = (wr_en && wr_sel == SEL_EN_CLR)   ? wsrc : '0;
  assign lv_set  = (wr_en && wr_sel == SEL_LVL_SET)  ? wsrc : '0;
  assign lv_clr  = (wr_en && wr_sel == SEL_LVL_CLR)  ? wsrc : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
      lvl0_q <= '0;
    end else begin
      flag_q <= (flag_q & ~w1c_clr & ~rd_clr) | evt;
      en_q   <= (en_q | en_set) & ~en_clr;
      lvl0_q <= (lvl0_q | lv_set) & ~lv_clr;
    end
  end

  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((flag_q & $past(evt)) == $past(evt)));

  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rd_clr & ~evt)) |=> ((flag_q & $past(rd_clr & ~evt)) == '0));

  a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (|(w1c_clr & ~evt)) |=> ((flag_q & $past(w1c_clr & ~evt)) == '0));

  a_r7_enable_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (|en_clr) |=> ((en_q & $past(en_clr)) == '0));

  a_r11_bad_sel_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel > SEL_LVL_CLR) |=> ($stable(en_q) && $stable(lvl0_q)));
endmodule

// File: rtl/sirq_prio.sv
`timescale 1ns/1ps
module sirq_prio
  import sirq_pkg::*;
#(
  parameter int N = NSRC,
  parameter int C = CODE_W
) (
  input  logic [N-1:0] pend,
  output logic [C-1:0] code,
  output logic [N-1:0] hit
);
  // lowest index carries the lowest code, so it is visited last and wins
  always_comb begin
    code = '0;
    hit  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        code = src_code(i);
        hit  = '0;
        hit[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sio_irq_vector.sv
`timescale 1ns/1ps
module sio_irq_vector
  import sirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   evt_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              vec0_rd_i,
  input  logic              vec1_rd_i,
  output logic [DATA_W-1:0] flag_o,
  output logic [DATA_W-1:0] enable_o,
  output logic [DATA_W-1:0] level_o,
  output logic [CODE_W-1:0] vec0_o,
  output logic [CODE_W-1:0] vec1_o,
  output logic              irq0_o,
  output logic              irq1_o
);
  localparam int NLVL = 2;

  logic [NSRC-1:0]   flag_q, en_q, lvl0_q;
  logic [NSRC-1:0]   pend [NLVL];
  logic [NSRC-1:0]   hit  [NLVL];
  logic [CODE_W-1:0] code [NLVL];
  logic [NLVL-1:0]   rd, irq;
  logic [NSRC-1:0]   rd_clr;

  assign rd = {vec1_rd_i, vec0_rd_i};

  sirq_regs #(.N(NSRC), .W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .evt(evt_i),
    .wr_en(wr_en_i), .wr_sel(wr_sel_i), .wr_data(wr_data_i),
    .rd_clr(rd_clr), .flag_q(flag_q), .en_q(en_q), .lvl0_q(lvl0_q)
  );

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    assign pend[g] = flag_q & en_q & ((g == 0) ? lvl0_q : ~lvl0_q);
    sirq_prio #(.N(NSRC), .C(CODE_W)) u_prio (
      .pend(pend[g]), .code(code[g]), .hit(hit[g])
    );
    assign irq[g] = |pend[g];
  end

  assign rd_clr   = (rd[0] ? hit[0] : '0) | (rd[1] ? hit[1] : '0);
  assign flag_o   = scatter(flag_q);
  assign enable_o = scatter(en_q);
  assign level_o  = scatter(lvl0_q);
  assign vec0_o   = code[0];
  assign vec1_o   = code[1];
  assign irq0_o   = irq[0];
  assign irq1_o   = irq[1];

  a_r9_irq0_vs_vec: assert property (@(posedge clk) disable iff (!rst_n)
    irq0_o == (vec0_o != '0));
  a_r9_irq1_vs_vec: assert property (@(posedge clk) disable iff (!rst_n)
    irq1_o == (vec1_o != '0));
  a_r4_single_pick: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit[0]) && $onehot0(hit[1]));
  a_r8_levels_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    (hit[0] & hit[1]) == '0);
  a_r7_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit[0] | hit[1]) & ~en_q) == '0);
endmodule

// File: tb/sio_irq_vector_tb.sv
`timescale 1ns/1ps
module sio_irq_vector_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic [6:0] evt;
  logic wr_en;
  logic [2:0] wr_sel;
  logic [31:0] wr_data;
  logic rd0, rd1;
  logic [31:0] flag_o, enable_o, level_o;
  logic [3:0] vec0, vec1;
  logic irq0, irq1;

  sio_irq_vector u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .vec0_rd_i(rd0), .vec1_rd_i(rd1), .flag_o(flag_o),
    .enable_o(enable_o), .level_o(level_o), .vec0_o(vec0), .vec1_o(vec1),
    .irq0_o(irq0), .irq1_o(irq1)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int pos [7] = '{1, 24, 26, 0, 25, 9, 8};
  int cd  [7] = '{1, 3, 6, 7, 9, 11, 12};
  logic [6:0] ef, ee, el;

  function automatic logic [31:0] spread(input logic [6:0] s);
    logic [31:0] r = '0;
    for (int i = 0; i < 7; i++) if (s[i]) r = r | (32'h1 << pos[i]);
    return r;
  endfunction

  function automatic logic [3:0] best(input logic [6:0] s);
    int m = 0;
    for (int i = 0; i < 7; i++) if (s[i] && (m == 0 || cd[i] < m)) m = cd[i];
    return 4'(m);
  endfunction

  function automatic logic [6:0] src_of(input logic [3:0] c);
    logic [6:0] r = '0;
    for (int i = 0; i < 7; i++) if (cd[i] == int'(c)) r[i] = 1'b1;
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [6:0] p0, p1;
    p0 = ef & ee & el;
    p1 = ef & ee & ~el;
    chk(flag_o == spread(ef), {tag, " R2 flags"}, flag_o, spread(ef));
    chk(enable_o == spread(ee), {tag, " R7 enable"}, enable_o, spread(ee));
    chk(level_o == spread(el), {tag, " R8 level"}, level_o, spread(el));
    chk(vec0 == best(p0), {tag, " R3/R4 vec0"}, 32'(vec0), 32'(best(p0)));
    chk(vec1 == best(p1), {tag, " R3/R4 vec1"}, 32'(vec1), 32'(best(p1)));
    chk(irq0 == (|p0), {tag, " R9 irq0"}, 32'(irq0), 32'(|p0));
    chk(irq1 == (|p1), {tag, " R9 irq1"}, 32'(irq1), 32'(|p1));
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    logic [6:0] s = '0;
    for (int i = 0; i < 7; i++) s[i] = d[pos[i]];
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    case (sel)
      3'd0: ef = ef & ~s;
      3'd1: ee = ee | s;
      3'd2: ee = ee & ~s;
      3'd3: el = el | s;
      3'd4: el = el & ~s;
      default: ;
    endcase
  endtask

  task automatic pulse(input logic [6:0] e);
    @(negedge clk);
    evt = e;
    @(negedge clk);
    evt = '0;
    ef = ef | e;
  endtask

  task automatic rdvec(input bit lvl, input string tag);
    logic [6:0] p;
    logic [3:0] c, exp;
    p = ef & ee & (lvl ? ~el : el);
    exp = best(p);
    @(negedge clk);
    if (lvl) rd1 = 1'b1; else rd0 = 1'b1;
    #1;
    c = lvl ? vec1 : vec0;
    chk(c == exp, {tag, " R4 code at read"}, 32'(c), 32'(exp));
    @(negedge clk);
    rd0 = 1'b0; rd1 = 1'b0;
    ef = ef & ~src_of(exp);
    chk(flag_o == spread(ef), {tag, " R5 flags after read"}, flag_o, spread(ef));
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
    $finish;
  end

  initial begin
    rst_n = 0; evt = '0; wr_en = 0; wr_sel = '0; wr_data = '0; rd0 = 0; rd1 = 0;
    ef = '0; ee = '0; el = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1 reset");

    // R7: flags without enable drive nothing
    pulse(7'h7F);
    check_all("R7 disabled flags");
    chk(!irq0 && !irq1 && vec0 == 0 && vec1 == 0, "R7 no output when disabled", 32'({irq0, irq1}), 0);

    // R8: default routing puts everything on level 1
    wr(3'd1, 32'hFFFF_FFFF);
    check_all("R8 default level1");
    chk(vec1 == 4'd1, "R3 wakeup code", 32'(vec1), 1);

    // R11: unused selects change nothing
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    check_all("R11 unused selects");

    // R6: clear only overrun, then unused bits
    wr(3'd0, 32'h0200_0000);
    check_all("R6 overrun only");
    wr(3'd0, 32'h00F0_00F4);
    check_all("R6 unused bits");

    // R4: overrun with receive gives 9
    wr(3'd0, 32'hFFFF_FFFF);
    pulse(7'b0110000);
    check_all("R4 overrun vs rx");
    chk(vec1 == 4'd9, "R4 overrun beats receive", 32'(vec1), 9);

    // R7: clear enable of overrun, receive now shows
    wr(3'd2, 32'h0200_0000);
    check_all("R7 enable clear");
    chk(vec1 == 4'd11, "R7 masked overrun hidden", 32'(vec1), 11);
    wr(3'd1, 32'h0200_0000);

    // R10: event and read-clear on same flag
    wr(3'd0, 32'hFFFF_FFFF);
    pulse(7'b0100000);
    @(negedge clk);
    rd1 = 1'b1; evt = 7'b0100000;
    @(negedge clk);
    rd1 = 1'b0; evt = '0;
    chk(flag_o[9] == 1'b1, "R10 event wins over read clear", 32'(flag_o[9]), 1);
    check_all("R10 state");

    // Sweep: every pending pattern under four level splits, drained by reads
    for (int p = 1; p < 128; p++) begin
      for (int k = 0; k < 4; k++) begin
        logic [6:0] l;
        case (k)
          0: l = 7'h00;
          1: l = 7'h7F;
          2: l = 7'h55;
          default: l = 7'(p) ^ 7'h2A;
        endcase
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd4, 32'hFFFF_FFFF);
        wr(3'd3, spread(l));
        pulse(7'(p));
        check_all("R2/R3 sweep");
        for (int n = 0; n < 8; n++) begin
          if ((ef & ee & el) != 0) rdvec(1'b0, "R5 sweep l0");
          else if ((ef & ee & ~el) != 0) rdvec(1'b1, "R5 sweep l1");
        end
        check_all("R9 sweep drained");
      end
    end

    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule